// File: doc/BRIEF.md
# Dual-Channel Compare Timer with Qualified Zero Match

This block is a 16-bit up-counter with two compare channels. The counter advances by one on every cycle in which the count-enable tick is high. Each channel holds a compare value that is loaded through its own write strobe. A channel is active only when both of its mode-select bits are 1. When the counter steps onto a channel's compare value, that channel raises a one-cycle interrupt pulse and a match event toggles the timer output flip-flop.

A compare value of zero needs special care. The counter's zero counts as a match only when it is reached by wrapping from FFFFH. It is not a match when the zero comes from a clear-on-match, or when it is loaded by the start control.

Channel 0 can also restart the period. When clear-on-match is enabled and channel 0 matches, the next count step loads zero instead of incrementing. A channel-1 match never changes the counter.

Top module: `cmp_timer`

## Requirements
- R1: While rst_n is low at a clock edge, count becomes 0, irq0 and irq1 become 0, and tout becomes 0.
- R2: On an edge with tick=1 and start=0, count advances by one, with FFFFH followed by 0000H, unless a clear is pending (R9). With tick=0 and start=0, count holds.
- R3: A channel is in compare mode only when its mode bits equal 2'b11. With any other mode value, its interrupt never pulses.
- R4: When a count step makes count equal to a nonzero compare value of a channel in compare mode, that channel's irq is 1 during the same cycle in which count first shows the value, and 0 in the following cycle unless a new match occurs.
- R5: tout toggles once for every cycle in which irq0 or irq1 is 1. This includes a cycle in which both are 1, where tout still toggles only once. tout is otherwise steady.
- R6: A compare value of 0000H matches when count steps from FFFFH to 0000H.
- R7: The 0000H produced by a clear-on-match is never a match for either channel.
- R8: start=1 loads count with 0000H and cancels any pending clear. start takes priority over tick. That zero does not raise either irq.
- R9: If clr_en is 1 on the edge where channel 0 matches, the next count step loads 0000H instead of incrementing. If clr_en is 0, counting continues.
- R10: A channel-1 match never changes the counter value, whatever the value of clr_en.
- R11: A cycle without a count step (tick=0) never raises an irq, even while count equals a compare value.
- R12: A compare-value write takes effect at the clock edge of the write strobe. A count step on that same edge is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| start | input | 1 | Load counter with zero as a non-matching start value |
| wr_en | input | 2 | Per-channel compare-register write strobe (bit k = channel k) |
| wr_data | input | 16 | Compare value to write |
| mode0 | input | 2 | Channel 0 mode; 2'b11 = compare |
| mode1 | input | 2 | Channel 1 mode; 2'b11 = compare |
| clr_en | input | 1 | Channel 0 clear-on-match enable |
| irq0 | output | 1 | Channel 0 match pulse |
| irq1 | output | 1 | Channel 1 match pulse |
| tout | output | 1 | Timer output, toggled by matches |
| count | output | 16 | Current counter value |

## Verification
Every result of this block is due one clock edge after the stimulus. The edge that steps the counter also updates irq0, irq1 and tout, a write lands on the edge of its strobe, and a pending clear shows on the next stepping edge. The bench drives inputs on the falling edge and steps a reference model once per cycle. It compares all outputs at the following falling edge, so each check samples exactly the cycle in which the value first appears. Directed runs cover the full wrap, clear-on-match followed by a zero compare, start colliding with tick, simultaneous matches and inactive modes. These are followed by a seeded random mix with small compare values, so that matches occur often.

// File: rtl/cmp_timer_pkg.sv
// Shared types and constants for the compare timer.
// Assumes two channels, each with a two-bit mode field.
package cmp_timer_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_RES_A = 2'b01,
        MODE_RES_B = 2'b10,
        MODE_CMP   = 2'b11
    } ch_mode_e;
endpackage

// File: rtl/cmp_counter.sv
// Up-counter with start load and deferred clear-on-match.
// Provides the value the next step will produce (nxt_val), so that the
// channels can judge a match on the same edge that the counter advances.
// Assumes start has priority over tick.
module cmp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic         clr_req,
    output logic [W-1:0] count,
    output logic [W-1:0] nxt_val,
    output logic         step,
    output logic         zero_ok
);
    logic clr_pend;

    // Next value and qualifiers for the channels.
    always_comb begin
        step    = tick & ~start;
        nxt_val = clr_pend ? '0 : count + {{(W-1){1'b0}}, 1'b1};
        zero_ok = ~clr_pend;
    end

    // Counter register and pending-clear flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            clr_pend <= 1'b0;
        end else if (start) begin
            count    <= '0;
            clr_pend <= 1'b0;
        end else if (tick) begin
            count    <= nxt_val;
            clr_pend <= clr_req;
        end
    end
endmodule

// File: rtl/cmp_channel.sv
// One compare channel: holds the compare value and judges a match against
// the counter's next value. A zero next value matches only on a wrap.
module cmp_channel
    import cmp_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   mode,
    input  logic         step,
    input  logic [W-1:0] nxt_val,
    input  logic         zero_ok,
    output logic         hit
);
    logic [W-1:0] cmp_q;

    // Compare register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_en) begin
            cmp_q <= wr_data;
        end
    end

    // Match judgement on the value the coming step produces.
    always_comb begin
        hit = step && (ch_mode_e'(mode) == MODE_CMP) && (cmp_q == nxt_val)
              && ((|nxt_val) || zero_ok);
    end
endmodule

// File: rtl/cmp_outctl.sv
// Output controller: registers the per-channel match pulses and toggles
// the timer output once per cycle with any match.
module cmp_outctl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    output logic [N-1:0] irq,
    output logic         tout
);
    // Pulse and toggle registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= '0;
            tout <= 1'b0;
        end else begin
            irq  <= hit;
            tout <= tout ^ (|hit);
        end
    end
endmodule

// File: rtl/cmp_timer.sv
// Top of the dual-channel compare timer. Channel 0 may clear the counter
// on its match; channel 1 never touches the counter.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic [1:0]   wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   mode0,
    input  logic [1:0]   mode1,
    input  logic         clr_en,
    output logic         irq0,
    output logic         irq1,
    output logic         tout,
    output logic [W-1:0] count
);
    logic [W-1:0]      nxt_val;
    logic              step;
    logic              zero_ok;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] irq;
    logic [1:0]        mode_a [NUM_CH];
    logic              clr_req;

    // Gather per-channel mode fields and the clear request.
    always_comb begin
        mode_a[0] = mode0;
        mode_a[1] = mode1;
        clr_req   = hit[0] & clr_en;
    end

    cmp_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .clr_req(clr_req), .count(count), .nxt_val(nxt_val),
        .step(step), .zero_ok(zero_ok)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        cmp_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en[k]), .wr_data(wr_data),
            .mode(mode_a[k]), .step(step), .nxt_val(nxt_val),
            .zero_ok(zero_ok), .hit(hit[k])
        );
    end

    cmp_outctl #(.N(NUM_CH)) u_out (
        .clk(clk), .rst_n(rst_n), .hit(hit), .irq(irq), .tout(tout)
    );

    assign irq0 = irq[0];
    assign irq1 = irq[1];
endmodule

// File: rtl/cmp_timer_chk.sv
// Property checker for cmp_timer, attached with bind.
module cmp_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         start,
    input logic [1:0]   mode0,
    input logic [1:0]   mode1,
    input logic         irq0,
    input logic         irq1,
    input logic         tout,
    input logic [W-1:0] count
);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && !$past(start)) |->
            (count == $past(count) + 1'b1 || count == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(start)) |-> $stable(count));

    assert_mode0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> ($past(mode0) == 2'b11));

    assert_mode1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |-> ($past(mode1) == 2'b11));

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tout != $past(tout)) == (irq0 || irq1));

    // R6 and R7: a zero match always comes from a wrap.
    assert_zero_wrap0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 && count == '0) |-> ($past(count) == {W{1'b1}}));

    assert_zero_wrap1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq1 && count == '0) |-> ($past(count) == {W{1'b1}}));

    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (count == '0 && !irq0 && !irq1));

    assert_nostep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 || irq1) |-> ($past(tick) && !$past(start)));
endmodule

bind cmp_timer cmp_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .mode0(mode0), .mode1(mode1), .irq0(irq0), .irq1(irq1),
    .tout(tout), .count(count)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   wr_en = 2'b00;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   mode0 = 2'b00;
    logic [1:0]   mode1 = 2'b00;
    logic         clr_en = 1'b0;
    logic         irq0, irq1, tout;
    logic [W-1:0] count;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [W-1:0] m_cnt = '0;
    logic         m_clr = 1'b0;
    logic [W-1:0] m_cmp0 = '0, m_cmp1 = '0;
    logic         m_irq0 = 1'b0, m_irq1 = 1'b0, m_tout = 1'b0;

    cmp_timer #(.W(W)) i_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .wr_en(wr_en), .wr_data(wr_data), .mode0(mode0), .mode1(mode1),
        .clr_en(clr_en), .irq0(irq0), .irq1(irq1), .tout(tout), .count(count)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic judge(input logic [1:0] md, input logic [W-1:0] cv,
                                   input logic [W-1:0] nv, input logic wrapz);
        return (md == 2'b11) && (cv == nv) && (nv != '0 || wrapz);
    endfunction

    // Advance the model by one edge with the present inputs.
    task automatic model_step();
        logic [W-1:0] nv;
        logic wrapz, h0, h1;
        nv    = m_clr ? '0 : m_cnt + 1'b1;
        wrapz = !m_clr;
        h0 = tick && !start && judge(mode0, m_cmp0, nv, wrapz);
        h1 = tick && !start && judge(mode1, m_cmp1, nv, wrapz);
        if (start) begin
            m_cnt = '0; m_clr = 1'b0;
        end else if (tick) begin
            m_cnt = nv; m_clr = h0 && clr_en;
        end
        m_irq0 = h0; m_irq1 = h1;
        m_tout = m_tout ^ (h0 | h1);
        if (wr_en[0]) m_cmp0 = wr_data;
        if (wr_en[1]) m_cmp1 = wr_data;
    endtask

    // One cycle: drive, step model, sample at the next falling edge.
    task automatic cyc(input logic tk, input logic st, input logic [1:0] we, input logic [W-1:0] wd);
        tick = tk; start = st; wr_en = we; wr_data = wd;
        model_step();
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; start = 1'b0; wr_en = 2'b00;
        check("R2 count", count, m_cnt);
        check("R4 irq0", {15'd0, irq0}, {15'd0, m_irq0});
        check("R4 irq1", {15'd0, irq1}, {15'd0, m_irq1});
        check("R5 tout", {15'd0, tout}, {15'd0, m_tout});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'b00, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic t0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 count", count, '0);
        check("R1 irq0", {15'd0, irq0}, 16'd0);
        check("R1 tout", {15'd0, tout}, 16'd0);
        rst_n = 1'b1;

        // R8: start loads zero, zero compare does not match; start beats tick
        mode0 = 2'b11;
        cyc(1'b0, 1'b0, 2'b01, 16'h0000);
        ticks(2);
        cyc(1'b0, 1'b1, 2'b00, '0);
        check("R8 start zero", count, 16'h0000);
        cyc(1'b1, 1'b1, 2'b00, '0);
        check("R8 start over tick", count, 16'h0000);
        check("R8 no irq", {15'd0, irq0}, 16'd0);

        // R4 / R11: nonzero match, then hold does not retrigger
        cyc(1'b0, 1'b0, 2'b01, 16'd3);
        t0 = tout;
        ticks(3);
        check("R4 match irq0", {15'd0, irq0}, 16'd1);
        check("R5 toggled", {15'd0, tout}, {15'd0, ~t0});
        cyc(1'b0, 1'b0, 2'b00, '0);
        check("R11 hold no irq", {15'd0, irq0}, 16'd0);
        check("R11 count held", count, 16'd3);

        // R3: inactive mode never pulses
        mode0 = 2'b10;
        cyc(1'b0, 1'b0, 2'b01, 16'd5);
        ticks(2);
        check("R3 count at cmp", count, 16'd5);
        check("R3 no irq", {15'd0, irq0}, 16'd0);

        // R9 / R7: clear after ch0 match, cleared zero is not a match
        mode0 = 2'b11; mode1 = 2'b11; clr_en = 1'b1;
        cyc(1'b0, 1'b1, 2'b01, 16'd4);
        cyc(1'b0, 1'b0, 2'b10, 16'd0);
        ticks(4);
        check("R9 match", {15'd0, irq0}, 16'd1);
        ticks(1);
        check("R9 cleared", count, 16'd0);
        check("R7 no zero irq", {15'd0, irq1}, 16'd0);
        ticks(1);
        check("R9 resume", count, 16'd1);

        // R10: ch1 match does not clear
        mode0 = 2'b00;
        cyc(1'b0, 1'b1, 2'b10, 16'd2);
        ticks(2);
        check("R10 irq1", {15'd0, irq1}, 16'd1);
        ticks(1);
        check("R10 no clear", count, 16'd3);

        // R12: write and step on the same edge uses old value
        mode1 = 2'b11; clr_en = 1'b0;
        cyc(1'b1, 1'b0, 2'b10, 16'd4);
        check("R12 old value", {15'd0, irq1}, 16'd0);
        cyc(1'b0, 1'b0, 2'b10, 16'd5);
        ticks(1);
        check("R12 new value", {15'd0, irq1}, 16'd1);

        // R5: both channels at once toggle once
        mode0 = 2'b11;
        cyc(1'b0, 1'b1, 2'b11, 16'd6);
        t0 = tout;
        ticks(6);
        check("R5 both irq", {14'd0, irq1, irq0}, 16'd3);
        check("R5 single toggle", {15'd0, tout}, {15'd0, ~t0});

        // R6: zero compare matches on wrap; FFFF matches on ch0
        cyc(1'b0, 1'b1, 2'b01, 16'hFFFF);
        cyc(1'b0, 1'b0, 2'b10, 16'h0000);
        ticks(65535);
        check("R6 ch0 at FFFF", {15'd0, irq0}, 16'd1);
        ticks(1);
        check("R6 wrap count", count, 16'h0000);
        check("R6 wrap zero irq", {15'd0, irq1}, 16'd1);

        // Random mix, checked against the model
        for (int i = 0; i < 20000; i++) begin
            mode0  = ($urandom % 4 != 0) ? 2'b11 : 2'($urandom);
            mode1  = ($urandom % 4 != 0) ? 2'b11 : 2'($urandom);
            clr_en = 1'($urandom);
            cyc(($urandom % 10) < 7, ($urandom % 60) == 0,
                (($urandom % 8) == 0) ? 2'($urandom) : 2'b00,
                W'($urandom % 24));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule